// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a memory-mapped SPI master. A host configures it and moves data through a small register bus with one register per address. It holds a control byte, a status byte, a bit-rate divider, a 16-bit command word and a data register. From these it drives the serial clock, the outgoing data line and an active-low slave select, and it samples the incoming data line.

A serial frame starts only when the host writes the data register. The word waits in a holding register, then moves into the shifter. Frames run in full-duplex mode, which stores the received word, or in transmit-only mode, which discards what comes in. The command word sets the frame length through a 4-bit code, the clock polarity and phase, the bit order, and whether slave select stays asserted between frames. A level interrupt combines the receive-full and transmit-empty flags, each with its own enable.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x20 (only transmit-empty set), the clock output is low, slave select is high and the interrupt is low.
- R2: The word moves from the holding register into the shifter on the clock edge after the write that placed it there. The serial clock toggles every divider+1 input cycles, so a frame of N bits ends 2·N·(divider+1) cycles after that move. Receive-full rises on the edge that ends the frame.
- R3: Command bits 11:8 set the frame length. Codes 7 to 15 give code+1 bits. Code 0 gives 20 bits, code 1 gives 24 and code 2 gives 32. Codes 3 to 6 give 8 bits. A frame has exactly 2·N clock edges.
- R4: Command bit 1 (polarity) sets the idle clock level. Command bit 0 (phase) selects the sampling edge: the leading edge when 0, the trailing edge when 1. The output bit is stable on each sampling edge.
- R5: Command bit 12 set sends the least significant bit first. When it is clear, bit N−1 goes first.
- R6: In full-duplex mode, reading the data register (offset 0x04) returns the received N bits right-aligned with zeros above them. Reading it clears receive-full (status bit 7).
- R7: Writing the data register clears transmit-empty (status bit 5). The flag returns to 1 when the word moves into the shifter.
- R8: When control bit 1 (transmit-only) is set, a finished frame neither sets receive-full nor changes the receive buffer.
- R9: If a full-duplex frame ends while receive-full is still set, the overrun flag (status bit 0) sets and the buffer keeps the earlier word. Writing 0 to status bit 0 clears overrun. Writing 1 leaves it unchanged.
- R10: The interrupt is high exactly when (receive-full and control bit 7) or (transmit-empty and control bit 5).
- R11: Slave select asserts when control bit 6 goes from 0 to 1 and when a frame starts. At the end of a frame it negates unless command bit 7 (keep) is set. When bit 6 is cleared, slave select negates at once if idle, or at the end of the frame in progress.
- R12: A frame starts only while control bits 6 (enable) and 3 (master) are both set. A word written while either bit is clear waits, and no clock edges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the data register) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Level interrupt |

## Verification
Each result has a fixed latency. Transmit-empty falls one edge after the data write and rises one edge later, when the word moves into the shifter; slave select asserts on that same edge. Receive-full rises 2·N·(divider+1) edges after the move. The bench samples at the falling clock edge after each of these rising edges. It also samples one edge before the receive-full deadline, so a frame that ends early or late is caught. Serial bit order and edge counts come from a monitor that watches the clock pins; those checks run one cycle after the frame ends, so the monitor has seen the final edge.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int unsigned LEN_W = 6;

  typedef struct packed {
    logic rx_ie;
    logic en;
    logic tx_ie;
    logic master;
    logic tx_only;
  } ctrl_t;

  typedef struct packed {
    logic       lsb_first;
    logic [3:0] len_code;
    logic       keep;
    logic       cpol;
    logic       cpha;
  } cmd_t;

  // Frame length in bits from the 4-bit code of the command word.
  function automatic logic [LEN_W-1:0] frame_bits(input logic [3:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      4'd0:    n = 6'd20;
      4'd1:    n = 6'd24;
      4'd2:    n = 6'd32;
      4'd3, 4'd4, 4'd5, 4'd6: n = 6'd8;
      default: n = {2'b00, code} + 6'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == div);
  assign tick = run & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] bits,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsbf,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_word
);

  localparam int unsigned HW  = LW + 1;
  localparam logic [HW-1:0] DWL = HW'(DW);

  logic          busy_q, busy_d;
  logic          sck_q, sck_d;
  logic [HW-1:0] half_q, half_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_nx;
  logic [LW-1:0] bits_q, bits_d;
  logic          cpha_q, cpha_d;
  logic          lsbf_q, lsbf_d;

  logic [HW-1:0] last_half;
  logic          lead, smp, shf;
  logic [HW-1:0] load_sh, out_sh;

  assign last_half = {bits_q, 1'b0} - 1'b1;
  assign lead      = ~half_q[0];
  assign smp       = busy_q & tick & (cpha_q ? ~lead : lead);
  assign shf       = busy_q & tick &
                     (cpha_q ? (lead & (half_q != '0)) : (~lead & (half_q != last_half)));
  assign done      = busy_q & tick & (half_q == last_half);

  assign load_sh = DWL - {1'b0, bits};
  assign out_sh  = DWL - {1'b0, bits_q};

  always_comb begin
    rx_nx = rx_q;
    if (smp) rx_nx = lsbf_q ? {miso, rx_q[DW-1:1]} : {rx_q[DW-2:0], miso};
  end

  assign rx_word = lsbf_q ? (rx_nx >> out_sh) : rx_nx;
  assign mosi    = lsbf_q ? tx_q[0] : tx_q[DW-1];
  assign busy    = busy_q;
  assign sck     = sck_q;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    half_d = half_q;
    tx_d   = tx_q;
    bits_d = bits_q;
    cpha_d = cpha_q;
    lsbf_d = lsbf_q;
    if (start) begin
      busy_d = 1'b1;
      sck_d  = cpol;
      half_d = '0;
      tx_d   = lsbf ? din : (din << load_sh);
      bits_d = bits;
      cpha_d = cpha;
      lsbf_d = lsbf;
    end else if (busy_q) begin
      if (tick) begin
        sck_d  = ~sck_q;
        half_d = half_q + 1'b1;
        if (shf) tx_d = lsbf_q ? (tx_q >> 1) : (tx_q << 1);
        if (done) busy_d = 1'b0;
      end
    end else begin
      sck_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      half_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      bits_q <= LW'(8);
      cpha_q <= 1'b0;
      lsbf_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      half_q <= half_d;
      tx_q   <= tx_d;
      rx_q   <= start ? '0 : rx_nx;
      bits_q <= bits_d;
      cpha_q <= cpha_d;
      lsbf_q <= lsbf_d;
    end
  end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 32,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             start,
  input  logic             busy,
  input  logic             done,
  input  logic [DW-1:0]    rx_word,
  output ctrl_t            ctrl,
  output cmd_t             cmd,
  output logic [DIV_W-1:0] div,
  output logic [DW-1:0]    hold,
  output logic             hold_full,
  output logic             rx_full,
  output logic             ovr,
  output logic             ss_act,
  output logic             rd_rx
);

  localparam logic [AW-1:0] OFS_CTRL = AW'(5'h00);
  localparam logic [AW-1:0] OFS_STAT = AW'(5'h03);
  localparam logic [AW-1:0] OFS_DATA = AW'(5'h04);
  localparam logic [AW-1:0] OFS_DIV  = AW'(5'h0A);
  localparam logic [AW-1:0] OFS_CMD  = AW'(5'h10);

  ctrl_t            ctrl_q, ctrl_d;
  cmd_t             cmd_q, cmd_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DW-1:0]    hold_q, hold_d;
  logic             hfull_q, hfull_d;
  logic [DW-1:0]    rbuf_q, rbuf_d;
  logic             rfull_q, rfull_d;
  logic             ovr_q, ovr_d;
  logic             ss_q, ss_d;

  logic wr_ctrl, wr_stat, wr_data, wr_div, wr_cmd;
  logic full_eff, en_rise;

  assign wr_ctrl = bus_wr & (bus_addr == OFS_CTRL);
  assign wr_stat = bus_wr & (bus_addr == OFS_STAT);
  assign wr_data = bus_wr & (bus_addr == OFS_DATA);
  assign wr_div  = bus_wr & (bus_addr == OFS_DIV);
  assign wr_cmd  = bus_wr & (bus_addr == OFS_CMD);
  assign rd_rx   = bus_rd & (bus_addr == OFS_DATA);

  assign full_eff = rfull_q & ~rd_rx;
  assign en_rise  = wr_ctrl & bus_wdata[6] & ~ctrl_q.en;

  always_comb begin
    ctrl_d  = ctrl_q;
    cmd_d   = cmd_q;
    div_d   = div_q;
    hold_d  = hold_q;
    hfull_d = hfull_q;
    rbuf_d  = rbuf_q;
    rfull_d = full_eff;
    ovr_d   = ovr_q;
    ss_d    = ss_q;

    if (wr_ctrl) ctrl_d = '{rx_ie: bus_wdata[7], en: bus_wdata[6], tx_ie: bus_wdata[5],
                            master: bus_wdata[3], tx_only: bus_wdata[1]};
    if (wr_cmd)  cmd_d = '{lsb_first: bus_wdata[12], len_code: bus_wdata[11:8],
                           keep: bus_wdata[7], cpol: bus_wdata[1], cpha: bus_wdata[0]};
    if (wr_div)  div_d = bus_wdata[DIV_W-1:0];

    if (wr_data) begin
      hold_d  = bus_wdata;
      hfull_d = 1'b1;
    end else if (start) begin
      hfull_d = 1'b0;
    end

    if (wr_stat && !bus_wdata[0]) ovr_d = 1'b0;
    if (done && !ctrl_q.tx_only) begin
      if (full_eff) begin
        ovr_d = 1'b1;
      end else begin
        rbuf_d  = rx_word;
        rfull_d = 1'b1;
      end
    end

    if (start || en_rise)                          ss_d = 1'b1;
    else if (done && (!cmd_q.keep || !ctrl_q.en))  ss_d = 1'b0;
    else if (!ctrl_q.en && !busy)                  ss_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      div_q   <= '0;
      hold_q  <= '0;
      hfull_q <= 1'b0;
      rbuf_q  <= '0;
      rfull_q <= 1'b0;
      ovr_q   <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmd_q   <= cmd_d;
      div_q   <= div_d;
      hold_q  <= hold_d;
      hfull_q <= hfull_d;
      rbuf_q  <= rbuf_d;
      rfull_q <= rfull_d;
      ovr_q   <= ovr_d;
      ss_q    <= ss_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata[7:0]  = {ctrl_q.rx_ie, ctrl_q.en, ctrl_q.tx_ie, 1'b0,
                                   ctrl_q.master, 1'b0, ctrl_q.tx_only, 1'b0};
      OFS_STAT: bus_rdata[7:0]  = {rfull_q, 1'b0, ~hfull_q, 4'b0000, ovr_q};
      OFS_DATA: bus_rdata       = rbuf_q;
      OFS_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      OFS_CMD:  bus_rdata[15:0] = {3'b000, cmd_q.lsb_first, cmd_q.len_code, cmd_q.keep,
                                   5'b00000, cmd_q.cpol, cmd_q.cpha};
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign cmd       = cmd_q;
  assign div       = div_q;
  assign hold      = hold_q;
  assign hold_full = hfull_q;
  assign rx_full   = rfull_q;
  assign ovr       = ovr_q;
  assign ss_act    = ss_q;

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 32,
  parameter int unsigned DIV_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_ss_n,
  output logic          irq
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctrl_t            ctrl;
  cmd_t             cmd;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    hold, rx_word;
  logic             hold_full, rx_full, ovr, ss_act, rd_rx;
  logic             busy, tick, frame_done, start, tx_empty;
  logic             ctl_en, ctl_tx_only, cmd_cpol;

  assign ctl_en      = ctrl.en;
  assign ctl_tx_only = ctrl.tx_only;
  assign cmd_cpol    = cmd.cpol;
  assign tx_empty    = ~hold_full;
  assign start       = hold_full & ~busy & ctrl.en & ctrl.master;

  spi_host_regs #(.AW(AW), .DW(DW), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .start     (start),
    .busy      (busy),
    .done      (frame_done),
    .rx_word   (rx_word),
    .ctrl      (ctrl),
    .cmd       (cmd),
    .div       (div),
    .hold      (hold),
    .hold_full (hold_full),
    .rx_full   (rx_full),
    .ovr       (ovr),
    .ss_act    (ss_act),
    .rd_rx     (rd_rx)
  );

  spi_host_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (busy),
    .div   (div),
    .tick  (tick)
  );

  spi_host_shifter #(.DW(DW), .LW(LEN_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .tick    (tick),
    .din     (hold),
    .bits    (frame_bits(cmd.len_code)),
    .cpol    (cmd.cpol),
    .cpha    (cmd.cpha),
    .lsbf    (cmd.lsb_first),
    .miso    (spi_miso),
    .busy    (busy),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (frame_done),
    .rx_word (rx_word)
  );

  assign spi_ss_n = ~ss_act;
  assign irq      = (rx_full & ctrl.rx_ie) | (tx_empty & ctrl.tx_ie);

endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck,
  input logic cpol,
  input logic ss_n,
  input logic hold_full,
  input logic en,
  input logic done,
  input logic tx_only,
  input logic rx_full,
  input logic rd_rx,
  input logic ovr,
  input logic tx_empty,
  input logic irq
);

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol));

  // R11
  ss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ss_n);

  // R12
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(hold_full) && $past(en)));

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tx_only && rx_full && !rd_rx) |=> ovr);

  // R8
  tx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tx_only && !rx_full) |=> !rx_full);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_full || tx_empty));

endmodule

bind spi_host_ctrl spi_host_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .busy      (busy),
  .sck       (spi_sck),
  .cpol      (cmd_cpol),
  .ss_n      (spi_ss_n),
  .hold_full (hold_full),
  .en        (ctl_en),
  .done      (frame_done),
  .tx_only   (ctl_tx_only),
  .rx_full   (rx_full),
  .rd_rx     (rd_rx),
  .ovr       (ovr),
  .tx_empty  (tx_empty),
  .irq       (irq)
);

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h03, A_DATA = 5'h04,
                         A_DIV = 5'h0A, A_CMD = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = 5'h03;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_ss_n, irq;
  logic        inv = 1'b0;

  always #10 clk = ~clk;

  assign spi_miso = spi_mosi ^ inv;

  spi_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ss_n(spi_ss_n), .irq(irq)
  );

  int tests = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial monitor
  logic        mon_cpol = 1'b0, mon_cpha = 1'b0, prev_sck = 1'b0;
  int          edges = 0, nbits = 0;
  logic [31:0] seq = '0;

  always @(negedge clk) begin
    if (spi_sck !== prev_sck) begin
      edges++;
      if ((prev_sck == mon_cpol) ^ mon_cpha) begin
        seq = {seq[30:0], spi_mosi};
        nbits++;
      end
    end
    prev_sck = spi_sck;
  end

  function automatic int fbits(input logic [3:0] c);
    if (c == 4'd0) return 20;
    if (c == 4'd1) return 24;
    if (c == 4'd2) return 32;
    if (c < 4'd7)  return 8;
    return int'(c) + 1;
  endfunction

  function automatic logic [31:0] fmask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] exp_seq(input logic [31:0] d, input int n, input logic lsbf);
    logic [31:0] r;
    r = '0;
    if (!lsbf) return d & fmask(n);
    for (int i = 0; i < n; i++) r[n-1-i] = d[i];
    return r;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_STAT;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = A_STAT;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  logic [7:0]  ctrl_ie = 8'h00;
  logic [31:0] last_rx;

  task automatic run_frame(input logic [31:0] data, input logic [3:0] code,
                           input logic cpol, input logic cpha, input logic lsbf,
                           input logic keep, input logic [7:0] dv,
                           input logic txo, input logic iv, input logic drain);
    logic [31:0] s, r;
    logic pre;
    int n;
    n = fbits(code);
    wr(A_DIV, {24'h0, dv});
    wr(A_CMD, {19'h0, lsbf, code, keep, 5'h0, cpol, cpha});
    wr(A_CTRL, ctrl_ie | (txo ? 8'h4A : 8'h48));
    @(negedge clk); @(negedge clk);
    mon_cpol = cpol; mon_cpha = cpha; edges = 0; nbits = 0; seq = '0;
    prev_sck = spi_sck; inv = iv;
    check("R4 idle clock level", {31'h0, spi_sck}, {31'h0, cpol});
    peek(A_STAT, s); pre = s[7];
    wr(A_DATA, data);
    peek(A_STAT, s);
    check("R7 tx-empty cleared by write", {31'h0, s[5]}, 32'h0);
    @(negedge clk);
    peek(A_STAT, s);
    check("R7 tx-empty set on load", {31'h0, s[5]}, 32'h1);
    check("R11 select asserted at start", {31'h0, spi_ss_n}, 32'h0);
    repeat (2 * n * (int'(dv) + 1) - 1) @(negedge clk);
    peek(A_STAT, s);
    check("R2 rx-full not before frame end", {31'h0, s[7]}, {31'h0, pre});
    @(negedge clk);
    peek(A_STAT, s);
    check(txo ? "R8 tx-only leaves rx-full" : "R2 rx-full at frame end",
          {31'h0, s[7]}, txo ? {31'h0, pre} : 32'h1);
    @(negedge clk);
    check("R3 clock edges per frame", edges, 2 * n);
    check("R3 sampled bits per frame", nbits, n);
    check("R5 serial bit order", seq, exp_seq(data, n, lsbf));
    check("R4 clock returns to idle", {31'h0, spi_sck}, {31'h0, cpol});
    check("R11 select after frame", {31'h0, spi_ss_n}, {31'h0, ~keep});
    last_rx = (iv ? ~data : data) & fmask(n);
    if (drain && !txo) begin
      rd(A_DATA, r);
      check("R6 received word", r, last_rx);
      peek(A_STAT, s);
      check("R6 read clears rx-full", {31'h0, s[7]}, 32'h0);
    end
  endtask

  initial begin
    #(20 * 190000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s, r, e1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    peek(A_CTRL, r); check("R1 control reset", r, 32'h0);
    peek(A_STAT, s); check("R1 status reset", s, 32'h20);
    check("R1 clock low", {31'h0, spi_sck}, 32'h0);
    check("R1 select high", {31'h0, spi_ss_n}, 32'h1);
    check("R1 irq low", {31'h0, irq}, 32'h0);

    // R11 enable asserts select while idle
    wr(A_CMD, 32'h0780);
    wr(A_CTRL, 32'h48);
    check("R11 enable asserts select", {31'h0, spi_ss_n}, 32'h0);

    // directed frames over length codes and modes
    run_frame(32'h0000_00A5, 4'd7,  0, 0, 0, 0, 8'd0, 0, 0, 1);
    run_frame(32'h0000_C3A1, 4'd15, 1, 0, 1, 1, 8'd1, 0, 1, 1);
    run_frame(32'h000F_0A5C, 4'd0,  0, 1, 0, 0, 8'd2, 0, 0, 1);
    run_frame(32'h00A1_B2C3, 4'd1,  1, 1, 1, 0, 8'd0, 0, 0, 1);
    run_frame(32'hDEAD_BEEF, 4'd2,  0, 1, 1, 1, 8'd0, 0, 1, 1);
    run_frame(32'h0000_1234, 4'd4,  0, 0, 0, 0, 8'd0, 0, 0, 1);
    run_frame(32'h0000_0155, 4'd9,  1, 0, 0, 0, 8'd3, 0, 0, 1);

    // R8 transmit-only: buffer keeps its previous word
    run_frame(32'h0000_0077, 4'd7, 0, 0, 0, 0, 8'd0, 0, 0, 1);
    e1 = last_rx;
    run_frame(32'h0000_00EE, 4'd7, 0, 0, 0, 0, 8'd0, 1, 0, 1);
    peek(A_DATA, r);
    check("R8 buffer unchanged in tx-only", r, e1);

    // R9 overrun
    run_frame(32'h0000_0011, 4'd7, 0, 0, 0, 0, 8'd0, 0, 0, 0);
    e1 = last_rx;
    run_frame(32'h0000_0022, 4'd7, 0, 0, 0, 0, 8'd0, 0, 0, 0);
    peek(A_STAT, s);
    check("R9 overrun set", {31'h0, s[0]}, 32'h1);
    rd(A_DATA, r);
    check("R9 earlier word kept", r, e1);
    wr(A_STAT, 32'h1);
    peek(A_STAT, s);
    check("R9 writing 1 keeps overrun", {31'h0, s[0]}, 32'h1);
    wr(A_STAT, 32'h0);
    peek(A_STAT, s);
    check("R9 writing 0 clears overrun", {31'h0, s[0]}, 32'h0);

    // R10 interrupt sources
    wr(A_CTRL, 32'h68);
    check("R10 irq from tx-empty", {31'h0, irq}, 32'h1);
    wr(A_CTRL, 32'hC8);
    check("R10 irq masked tx-empty, rx empty", {31'h0, irq}, 32'h0);
    ctrl_ie = 8'h80;
    run_frame(32'h0000_005A, 4'd7, 0, 0, 0, 0, 8'd0, 0, 0, 0);
    check("R10 irq from rx-full", {31'h0, irq}, 32'h1);
    rd(A_DATA, r);
    check("R10 irq drops after read", {31'h0, irq}, 32'h0);
    ctrl_ie = 8'h00;

    // R12 no frame while enable is clear
    wr(A_CMD, 32'h0700);
    wr(A_CTRL, 32'h08);
    @(negedge clk);
    edges = 0; mon_cpol = 1'b0; prev_sck = spi_sck;
    wr(A_DATA, 32'h0000_00C3);
    repeat (60) @(negedge clk);
    check("R12 no clock edges while disabled", edges, 0);
    peek(A_STAT, s);
    check("R12 word still held", {31'h0, s[5]}, 32'h0);
    check("R11 select high while disabled", {31'h0, spi_ss_n}, 32'h1);
    wr(A_CTRL, 32'h40);
    repeat (30) @(negedge clk);
    check("R12 no frame without master bit", edges, 0);
    wr(A_CTRL, 32'h48);
    repeat (30) @(negedge clk);
    rd(A_DATA, r);
    check("R12 held word sent once enabled", r, 32'h0000_00C3);

    // R11 enable cleared mid-frame with keep set
    wr(A_DIV, 32'h3);
    wr(A_CMD, 32'h0F80);
    wr(A_DATA, 32'h0000_A55A);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h08);
    check("R11 select held during frame", {31'h0, spi_ss_n}, 32'h0);
    repeat (150) @(negedge clk);
    check("R11 select negated after frame", {31'h0, spi_ss_n}, 32'h1);
    rd(A_DATA, r);
    check("R6 mid-frame disable word", r, 32'h0000_A55A);
    wr(A_CTRL, 32'h48);

    // random frames
    for (int k = 0; k < 20; k++) begin
      logic [31:0] d;
      logic [3:0]  c;
      logic [7:0]  dv;
      d  = $urandom;
      c  = 4'($urandom % 16);
      dv = 8'($urandom % 3);
      run_frame(d, c, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                dv, 1'(($urandom % 4) == 0), 1'($urandom), 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule